// File: doc/BRIEF.md
# Slot Interrupt Router

The router turns a PCI-style interrupt pin raised by a device in a given bus slot into a line number on an internal interrupt controller. It then drives a single interrupt output toward the processor. The slot table is fixed and irregular:

- One slot spreads its four pins over four consecutive lines.
- Two slots each collapse all their pins onto one private line.
- A run of expansion slots rotates the pin index by the slot position, so that their loads spread across a shared group of lines.
- Slots outside the table keep their raw pin number, which falls outside the controller's window.

The controller's lines start at 32. Each line's internal index is its number minus 32. Two configuration words, each one bit per index, decide what a change on that line does:

- If the edge bit for the index is set, the output emits a single-clock pulse and then rests low.
- If the edge bit is clear, the output is raised or lowered to follow the polarity bit.

The mapped line number is available combinationally. The output interrupt only moves in the cycle after a change strobe.

Top module: `slot_irq_router`

## Requirements
- R1: Slot 5 maps pin n (0..3) to line 32 + n.
- R2: Slot 6 maps every pin to line 36, and slot 7 maps every pin to line 37.
- R3: Slot s in 8..12 maps pin n to line (s - 8 + n) + 38, which gives lines 38 to 45.
- R4: Any other slot puts out the pin number itself as the line, giving lines 0 to 3.
- R5: After reset the interrupt output is low.
- R6: A strobe on a line whose edge bit (bit index = line - 32) is 1 makes irq_o high in the following cycle only, then low, whatever its earlier level.
- R7: A strobe on a line whose edge bit is 0 sets irq_o, from the following cycle, to that line's polarity bit (1 raises, 0 lowers).
- R8: A strobe whose line lies outside 32..63 leaves irq_o unchanged.
- R9: Without a strobe, irq_o does not change, even when the slot, the pin or the configuration words change; a running pulse still ends after its one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 5 | Slot number of the requesting device |
| pin_i | input | 2 | Interrupt pin index, 0 = INTA to 3 = INTD |
| chg_i | input | 1 | Change strobe, one per interrupt event |
| edge_cfg_i | input | 32 | Per-index edge-mode bits |
| pol_cfg_i | input | 32 | Per-index polarity bits for level mode |
| line_o | output | 8 | Mapped interrupt line number |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions watch, on every cycle, the output's timing relations:
- an edge strobe gives a high output next cycle, which drops when no new strobe follows;
- a level strobe gives the polarity bit;
- an out-of-window strobe or no strobe at all leaves the output steady.

They also pin the fixed lines of slots 6 and 7 and the low range of pass-through slots. Only the bench scenarios show the full table: the rotation across all expansion slots and pins, the spread of slot 5, and a pulse cutting short a raised level before coming to rest low.

// File: rtl/slot_irq_router.sv
module slot_irq_router #(
  parameter int SLOT_W      = 5,
  parameter int PIN_W       = 2,
  parameter int LINE_W      = 8,
  parameter int LINE_BASE   = 32,
  parameter int NUM_LINES   = 32,
  parameter int SLOT_QUAD   = 5,
  parameter int SLOT_SOLO_A = 6,
  parameter int SLOT_SOLO_B = 7,
  parameter int SLOT_EXP_LO = 8,
  parameter int SLOT_EXP_HI = 12,
  parameter int SOLO_A_OFS  = 4,
  parameter int SOLO_B_OFS  = 5,
  parameter int EXP_OFS     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [PIN_W-1:0]     pin_i,
  input  logic                 chg_i,
  input  logic [NUM_LINES-1:0] edge_cfg_i,
  input  logic [NUM_LINES-1:0] pol_cfg_i,
  output logic [LINE_W-1:0]    line_o,
  output logic                 irq_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [LINE_W:0] WIN_LO = (LINE_W+1)'(LINE_BASE);
  localparam logic [LINE_W:0] WIN_HI = (LINE_W+1)'(LINE_BASE + NUM_LINES);

  logic             lvl_q, pls_q;
  logic             in_win;
  logic [IDX_W-1:0] idx;

  always_comb begin
    if (slot_i == SLOT_W'(SLOT_QUAD))
      line_o = LINE_W'(pin_i[1:0]) + LINE_W'(LINE_BASE);        // pin mod 4
    else if (slot_i == SLOT_W'(SLOT_SOLO_A))
      line_o = LINE_W'(SOLO_A_OFS + LINE_BASE);
    else if (slot_i == SLOT_W'(SLOT_SOLO_B))
      line_o = LINE_W'(SOLO_B_OFS + LINE_BASE);
    else if (slot_i >= SLOT_W'(SLOT_EXP_LO) && slot_i <= SLOT_W'(SLOT_EXP_HI))
      line_o = LINE_W'(slot_i) - LINE_W'(SLOT_EXP_LO) + LINE_W'(pin_i)
             + LINE_W'(EXP_OFS + LINE_BASE);
    else
      line_o = LINE_W'(pin_i);
  end

  assign in_win = ({1'b0, line_o} >= WIN_LO) && ({1'b0, line_o} < WIN_HI);
  assign idx    = IDX_W'(line_o - LINE_W'(LINE_BASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      pls_q <= 1'b0;
      if (chg_i && in_win) begin
        if (edge_cfg_i[idx]) begin
          pls_q <= 1'b1;
          lvl_q <= 1'b0;
        end else begin
          lvl_q <= pol_cfg_i[idx];
        end
      end
    end
  end

  assign irq_o = lvl_q | pls_q;

  AST_SOLO_A_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i == SLOT_W'(SLOT_SOLO_A) |-> line_o == LINE_W'(LINE_BASE + SOLO_A_OFS)); // R2
  AST_SOLO_B_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i == SLOT_W'(SLOT_SOLO_B) |-> line_o == LINE_W'(LINE_BASE + SOLO_B_OFS)); // R2
  AST_PASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i < SLOT_W'(SLOT_QUAD) || slot_i > SLOT_W'(SLOT_EXP_HI)) |-> !in_win); // R4
  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i && in_win && edge_cfg_i[idx] |=> irq_o); // R6
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q && !chg_i |=> !irq_o); // R6
  AST_LEVEL_POL: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i && in_win && !edge_cfg_i[idx] |=> irq_o == $past(pol_cfg_i[idx])); // R7
  AST_OUT_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i && !in_win && !pls_q |=> $stable(irq_o)); // R8
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_i && !pls_q |=> $stable(irq_o)); // R9
endmodule

// File: tb/slot_irq_router_bench.sv
module slot_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  slot_i = '0;
  logic [1:0]  pin_i = '0;
  logic        chg_i = 1'b0;
  logic [31:0] edge_cfg_i = '0;
  logic [31:0] pol_cfg_i = '0;
  logic [7:0]  line_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slot_irq_router u_slot_irq_router (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .pin_i(pin_i), .chg_i(chg_i),
    .edge_cfg_i(edge_cfg_i), .pol_cfg_i(pol_cfg_i), .line_o(line_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic map_check(input int s, input int p, input int exp, input string req);
    @(negedge clk);
    slot_i = 5'(s); pin_i = 2'(p);
    #1;
    check(line_o == 8'(exp), req, int'(line_o), exp);
  endtask

  task automatic strobe(input int s, input int p);
    @(negedge clk);
    slot_i = 5'(s); pin_i = 2'(p); chg_i = 1'b1;
    @(negedge clk);
    chg_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check(irq_o == 1'b0, "R5 reset", int'(irq_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b0, "R5 after release", int'(irq_o), 0);
  endtask

  task automatic t_map_quad;
    for (int p = 0; p < 4; p++) map_check(5, p, 32 + p, "R1 slot5");
  endtask

  task automatic t_map_solo;
    for (int p = 0; p < 4; p++) begin
      map_check(6, p, 36, "R2 slot6");
      map_check(7, p, 37, "R2 slot7");
    end
  endtask

  task automatic t_map_exp;
    for (int s = 8; s <= 12; s++)
      for (int p = 0; p < 4; p++) map_check(s, p, s - 8 + p + 38, "R3 expansion");
  endtask

  task automatic t_map_pass;
    for (int p = 0; p < 4; p++) begin
      map_check(0, p, p, "R4 slot0");
      map_check(4, p, p, "R4 slot4");
      map_check(13, p, p, "R4 slot13");
      map_check(31, p, p, "R4 slot31");
    end
  endtask

  task automatic t_level;
    edge_cfg_i = '0; pol_cfg_i = 32'h0000_2000;        // index 13 = line 45
    strobe(12, 3);
    check(irq_o == 1'b1, "R7 raise line45", int'(irq_o), 1);
    pol_cfg_i = '0;
    strobe(12, 3);
    check(irq_o == 1'b0, "R7 lower line45", int'(irq_o), 0);
    pol_cfg_i = 32'h0000_0001;                          // index 0 = line 32
    strobe(5, 0);
    check(irq_o == 1'b1, "R7 raise line32", int'(irq_o), 1);
  endtask

  task automatic t_edge;
    edge_cfg_i = 32'h0000_0010; pol_cfg_i = 32'h0000_0030; // index 4 edge, 5 level
    strobe(7, 2);
    check(irq_o == 1'b1, "R7 level on line37", int'(irq_o), 1);
    strobe(6, 1);
    check(irq_o == 1'b1, "R6 pulse high", int'(irq_o), 1);
    @(negedge clk);
    check(irq_o == 1'b0, "R6 pulse ends low", int'(irq_o), 0);
    @(negedge clk);
    check(irq_o == 1'b0, "R6 stays low", int'(irq_o), 0);
    strobe(6, 0);
    check(irq_o == 1'b1, "R6 pulse from low", int'(irq_o), 1);
    @(negedge clk);
    check(irq_o == 1'b0, "R6 pulse one cycle", int'(irq_o), 0);
  endtask

  task automatic t_out_window;
    edge_cfg_i = 32'hFFFF_FFFF; pol_cfg_i = 32'hFFFF_FFFF;
    edge_cfg_i[5] = 1'b0;
    strobe(7, 0);
    check(irq_o == 1'b1, "R8 setup high", int'(irq_o), 1);
    strobe(0, 2);
    check(irq_o == 1'b1, "R8 slot0 ignored", int'(irq_o), 1);
    @(negedge clk);
    check(irq_o == 1'b1, "R8 slot0 still held", int'(irq_o), 1);
    pol_cfg_i = '0; edge_cfg_i = '0;
    strobe(20, 3);
    check(irq_o == 1'b1, "R8 slot20 ignored", int'(irq_o), 1);
  endtask

  task automatic t_no_strobe;
    pol_cfg_i = '0; edge_cfg_i = 32'hFFFF_FFFF;
    @(negedge clk); slot_i = 5'd6; pin_i = 2'd0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      slot_i = 5'(8 + i);
      check(irq_o == 1'b1, "R9 no strobe holds", int'(irq_o), 1);
    end
    edge_cfg_i = '0;
    strobe(5, 1);
    check(irq_o == 1'b0, "R9 strobe then lowers", int'(irq_o), 0);
  endtask

  initial begin
    t_reset();
    t_map_quad();
    t_map_solo();
    t_map_exp();
    t_map_pass();
    t_level();
    t_edge();
    t_out_window();
    t_no_strobe();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule